// File: doc/BRIEF.md
# Serial Interface Clock Selector

This block produces the bit-timing enables that a UART-style serial shifter needs. A transmit shifter and a receive shifter each take a one-cycle tick in the system clock domain. Each side draws its tick from one of two sources. The first is an internal reloadable rate generator. The second is a serial clock pin driven from outside the block. The block can also drive that pin as an output. No clock is formed by gating logic: every output is a registered signal in the system clock domain.

In free-running (asynchronous) mode, the internal generator runs at sixteen times the bit rate. An external pin used as a source must also run at sixteen times the bit rate. A divide-by-sixteen stage turns either source into the bit tick. The transmit and receive sides choose their sources independently, in any combination. When the pin is driven out, it carries a continuous square wave at either the bit rate or sixteen times the bit rate.

In gated (synchronous) mode, a three-state machine drives the pin when the block is master. Its states are GATE_IDLE, GATE_HIGH and GATE_LOW. The transitions are:
- start: GATE_IDLE to GATE_HIGH, on a half-period tick while shifting is requested.
- fall: GATE_HIGH to GATE_LOW, on a half-period tick.
- rise: GATE_LOW to GATE_HIGH, on a half-period tick while shifting is still requested.
- stop: GATE_LOW to GATE_IDLE, on a half-period tick once shifting is no longer requested.
- abort: GATE_HIGH or GATE_LOW to GATE_IDLE, when gated master mode is left.

In gated mode the half period is clamped to at least four system clocks, so the pin never runs faster than one eighth of the system clock. As slave, the block follows the edges of the external pin instead.

Top module: `serial_tick_gen`

## Requirements
- R1: After reset, tx_tick, rx_tick, pin_out and pin_oe are all 0.
- R2: In free-running mode with a side's source select at 0 (internal), that side's tick pulses for one cycle every 32*(D+1) system clocks. D is the value on divisor.
- R3: In free-running mode with a side's source select at 1 (external), that side's tick pulses once for every 16 rising edges of ext_clk_in.
- R4: The two source selects act independently. One side can run from the internal generator while the other runs from the pin, each keeping its own period.
- R5: In free-running mode, pin_oe equals drive_en. With drive_en=1 and pin_rate_16x=1, pin_out toggles every D+1 system clocks.
- R6: In free-running mode, with drive_en=1 and pin_rate_16x=0, pin_out toggles every 16*(D+1) system clocks.
- R7: In gated mode with master=1, pin_oe is 1. pin_out toggles every E+1 system clocks, where E=max(D,3). rx_tick pulses in the cycle pin_out rises, and tx_tick pulses in the cycle pin_out falls.
- R8: In gated master mode, pin_out stays 0 and no tick pulses while shift_active is 0. The first rise comes E+1 clocks after shift_active is sampled at 1. When shift_active returns to 0, the pin finishes its current period, settles at 0, and the ticks stop.
- R9: In gated mode with master=0, pin_oe is 0. While shift_active is 1, rx_tick pulses once per rising edge of ext_clk_in and tx_tick pulses once per falling edge. While shift_active is 0, neither tick pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_in | input | 1 | Serial clock pin, input side |
| divisor | input | DIV_W | Half-period reload value D of the internal generator |
| sync_mode | input | 1 | 1 = gated mode, 0 = free-running mode |
| master | input | 1 | Gated mode: 1 = internal clock drives the pin, 0 = follow the pin |
| tx_src_ext | input | 1 | Free-running: transmit source, 1 = pin, 0 = internal |
| rx_src_ext | input | 1 | Free-running: receive source, 1 = pin, 0 = internal |
| drive_en | input | 1 | Free-running: drive the internal clock onto the pin |
| pin_rate_16x | input | 1 | Driven pin rate: 1 = sixteen times the bit rate, 0 = bit rate |
| shift_active | input | 1 | Gated mode: a transfer is in progress |
| tx_tick | output | 1 | One-cycle transmit bit enable |
| rx_tick | output | 1 | One-cycle receive bit enable |
| pin_out | output | 1 | Serial clock pin drive value |
| pin_oe | output | 1 | Serial clock pin output enable |

## Verification
The hardest behaviour to reach from the ports is the gated master start and stop. The first rise depends on the generator counter being held at zero while idle. Stopping must let the current period finish rather than cut it short. The bench parks the block idle with shift_active low for a long stretch, raises shift_active on a sampling edge, and counts clocks to the first rise. It does this for divisors below and above the clamp. It then drops shift_active mid-burst and watches the pin settle low with no further ticks.

// File: rtl/serial_tick_pkg.sv
package serial_tick_pkg;
    typedef enum logic [1:0] {
        GATE_IDLE = 2'd0,
        GATE_HIGH = 2'd1,
        GATE_LOW  = 2'd2
    } gate_state_e;
endpackage

// File: rtl/stg_rate_gen.sv
module stg_rate_gen #(
    parameter int DIV_W    = 8,
    parameter int OVS      = 16,
    parameter int MIN_HALF = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             sync_mode,
    input  logic             restart,
    output logic             half_tick,
    output logic             bit_tick,
    output logic             pin_os,
    output logic             pin_bit
);
    localparam int OVS_W = $clog2(OVS);
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(MIN_HALF - 1);
    localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] eff_div;
    logic             phase;
    logic [OVS_W-1:0] os_cnt;
    logic             os_tick;

    // the gated mode keeps the half period at MIN_HALF clocks or more
    always_comb begin
        if (sync_mode && (divisor < MIN_DIV)) eff_div = MIN_DIV;
        else                                  eff_div = divisor;
    end

    assign half_tick = (cnt >= eff_div);
    assign os_tick   = half_tick & phase;
    assign bit_tick  = os_tick & (os_cnt == OVS_LAST);
    assign pin_os    = phase;
    assign pin_bit   = os_cnt[OVS_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            phase  <= 1'b0;
            os_cnt <= '0;
        end else if (restart) begin
            cnt    <= '0;
            phase  <= 1'b0;
            os_cnt <= '0;
        end else begin
            if (half_tick) begin
                cnt   <= '0;
                phase <= ~phase;
            end else begin
                cnt <= cnt + 1'b1;
            end
            if (os_tick) os_cnt <= os_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/stg_ext_edge.sv
module stg_ext_edge #(
    parameter int STAGES = 2,
    parameter int OVS    = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall,
    output logic bit_tick
);
    localparam int OVS_W = $clog2(OVS);
    localparam logic [OVS_W-1:0] OVS_LAST = OVS_W'(OVS - 1);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic [OVS_W-1:0]  edge_cnt;

    for (genvar i = 0; i < STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= pin_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    assign rise     = sync_q[STAGES-1] & ~prev_q;
    assign fall     = ~sync_q[STAGES-1] & prev_q;
    assign bit_tick = rise & (edge_cnt == OVS_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q   <= 1'b0;
            edge_cnt <= '0;
        end else begin
            prev_q <= sync_q[STAGES-1];
            if (rise) edge_cnt <= edge_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/stg_gate_fsm.sv
module stg_gate_fsm
    import serial_tick_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic shift_active,
    input  logic half_tick,
    output logic restart,
    output logic rise_evt,
    output logic fall_evt,
    output logic high_next
);
    gate_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GATE_IDLE: if (enable && shift_active && half_tick) state_d = GATE_HIGH;
            GATE_HIGH: begin
                if (!enable)        state_d = GATE_IDLE;
                else if (half_tick) state_d = GATE_LOW;
            end
            GATE_LOW: begin
                if (!enable)        state_d = GATE_IDLE;
                else if (half_tick) state_d = shift_active ? GATE_HIGH : GATE_IDLE;
            end
            default: state_d = GATE_IDLE;
        endcase
    end

    assign high_next = (state_d == GATE_HIGH);
    assign rise_evt  = (state_d == GATE_HIGH) && (state_q != GATE_HIGH);
    assign fall_evt  = (state_q == GATE_HIGH) && (state_d == GATE_LOW);
    assign restart   = enable && (state_q == GATE_IDLE) && !shift_active;
endmodule

// File: rtl/serial_tick_gen.sv
module serial_tick_gen #(
    parameter int DIV_W       = 8,
    parameter int OVS         = 16,
    parameter int MIN_HALF    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_in,
    input  logic [DIV_W-1:0] divisor,
    input  logic             sync_mode,
    input  logic             master,
    input  logic             tx_src_ext,
    input  logic             rx_src_ext,
    input  logic             drive_en,
    input  logic             pin_rate_16x,
    input  logic             shift_active,
    output logic             tx_tick,
    output logic             rx_tick,
    output logic             pin_out,
    output logic             pin_oe
);
    logic gate_en;
    logic restart, half_tick, int_bit, pin_os, pin_bit;
    logic ext_rise, ext_fall, ext_bit;
    logic rise_evt, fall_evt, high_next;

    assign gate_en = sync_mode & master;

    stg_rate_gen #(.DIV_W(DIV_W), .OVS(OVS), .MIN_HALF(MIN_HALF)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .divisor   (divisor),
        .sync_mode (sync_mode),
        .restart   (restart),
        .half_tick (half_tick),
        .bit_tick  (int_bit),
        .pin_os    (pin_os),
        .pin_bit   (pin_bit)
    );

    stg_ext_edge #(.STAGES(SYNC_STAGES), .OVS(OVS)) u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (ext_clk_in),
        .rise     (ext_rise),
        .fall     (ext_fall),
        .bit_tick (ext_bit)
    );

    stg_gate_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (gate_en),
        .shift_active (shift_active),
        .half_tick    (half_tick),
        .restart      (restart),
        .rise_evt     (rise_evt),
        .fall_evt     (fall_evt),
        .high_next    (high_next)
    );

    // registered outputs, one process for the whole output set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_tick <= 1'b0;
            rx_tick <= 1'b0;
            pin_out <= 1'b0;
            pin_oe  <= 1'b0;
        end else if (sync_mode && master) begin
            tx_tick <= fall_evt;
            rx_tick <= rise_evt;
            pin_out <= high_next;
            pin_oe  <= 1'b1;
        end else if (sync_mode) begin
            tx_tick <= ext_fall & shift_active;
            rx_tick <= ext_rise & shift_active;
            pin_out <= 1'b0;
            pin_oe  <= 1'b0;
        end else begin
            tx_tick <= tx_src_ext ? ext_bit : int_bit;
            rx_tick <= rx_src_ext ? ext_bit : int_bit;
            pin_out <= drive_en & (pin_rate_16x ? pin_os : pin_bit);
            pin_oe  <= drive_en;
        end
    end
endmodule

// File: rtl/serial_tick_chk.sv
module serial_tick_chk #(
    parameter int MIN_HALF = 4
) (
    input logic clk,
    input logic rst_n,
    input logic sync_mode,
    input logic master,
    input logic shift_active,
    input logic tx_tick,
    input logic rx_tick,
    input logic pin_out,
    input logic pin_oe
);
    logic [7:0] gap;
    logic       prev_pin;
    logic       gm;

    assign gm = sync_mode & master;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap      <= 8'hFF;
            prev_pin <= 1'b0;
        end else begin
            prev_pin <= pin_out;
            if (!gm)                  gap <= 8'hFF;
            else if (pin_out != prev_pin) gap <= 8'd0;
            else if (gap != 8'hFF)    gap <= gap + 8'd1;
        end
    end

    always_comb begin
        if (!rst_n) assert_reset_quiet_R1: assert (!tx_tick && !rx_tick && !pin_out && !pin_oe);
    end

    assert_rise_gives_rx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gm && $past(gm) && $rose(pin_out)) |-> rx_tick);

    assert_fall_gives_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gm && $past(gm) && $fell(pin_out)) |-> tx_tick);

    assert_ticks_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gm |-> $onehot0({tx_tick, rx_tick}));

    assert_min_half_period_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gm && $past(gm) && (pin_out != $past(pin_out))) |-> (gap >= 8'(MIN_HALF - 1)));

    assert_slave_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sync_mode) && !$past(master) && !$past(shift_active)) |-> (!tx_tick && !rx_tick));

    assert_slave_no_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sync_mode) && !$past(master)) |-> !pin_oe);
endmodule

bind serial_tick_gen serial_tick_chk #(.MIN_HALF(MIN_HALF)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_mode    (sync_mode),
    .master       (master),
    .shift_active (shift_active),
    .tx_tick      (tx_tick),
    .rx_tick      (rx_tick),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe)
);

// File: tb/tb_serial_tick_gen.sv
module tb_serial_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk_in = 1'b0;
    logic [7:0] divisor = 8'd0;
    logic       sync_mode = 1'b0, master = 1'b0;
    logic       tx_src_ext = 1'b0, rx_src_ext = 1'b0;
    logic       drive_en = 1'b0, pin_rate_16x = 1'b0, shift_active = 1'b0;
    logic       tx_tick, rx_tick, pin_out, pin_oe;

    int total = 0;
    int bad = 0;
    int ext_half = 0;

    always #2.5 clk = ~clk;

    serial_tick_gen dut (
        .clk(clk), .rst_n(rst_n), .ext_clk_in(ext_clk_in), .divisor(divisor),
        .sync_mode(sync_mode), .master(master), .tx_src_ext(tx_src_ext),
        .rx_src_ext(rx_src_ext), .drive_en(drive_en), .pin_rate_16x(pin_rate_16x),
        .shift_active(shift_active), .tx_tick(tx_tick), .rx_tick(rx_tick),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // external pin: toggles every ext_half system clocks when ext_half > 0
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            if (ext_half > 0) begin
                c++;
                if (c >= ext_half) begin
                    ext_clk_in = ~ext_clk_in;
                    c = 0;
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // sel: 0 tx_tick, 1 rx_tick, 2 pin_out change; returns clocks to the event
    task automatic gap(input int sel, output int cycles);
        logic start_pin;
        bit   hit;
        start_pin = pin_out;
        cycles = 0;
        hit = 1'b0;
        while (!hit && cycles < 20000) begin
            @(negedge clk);
            cycles++;
            hit = (sel == 0) ? tx_tick : (sel == 1) ? rx_tick : (pin_out != start_pin);
            if (sel == 2 && hit) start_pin = pin_out;
        end
    endtask

    task automatic measure(input int sel, output int cycles);
        int dummy;
        gap(sel, dummy);
        gap(sel, dummy);
        gap(sel, cycles);
    endtask

    task automatic count_ticks(input int n, output int ticks);
        ticks = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx_tick || rx_tick) ticks++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int g, t, e, lat;
        repeat (3) @(negedge clk);
        check(!tx_tick && !rx_tick && !pin_out && !pin_oe, "R1 reset outputs",
              {tx_tick, rx_tick, pin_out, pin_oe}, 0);
        rst_n = 1'b1;

        // R2 internal source sweep, both sides
        for (int d = 0; d < 8; d++) begin
            divisor = 8'(d);
            measure(0, g);
            check(g == 32 * (d + 1), "R2 tx internal period", g, 32 * (d + 1));
            measure(1, g);
            check(g == 32 * (d + 1), "R2 rx internal period", g, 32 * (d + 1));
        end

        // R5 / R6 pin drive in free-running mode
        drive_en = 1'b1;
        for (int d = 0; d < 8; d += 3) begin
            divisor = 8'(d);
            pin_rate_16x = 1'b1;
            @(negedge clk);
            check(pin_oe == 1'b1, "R5 pin_oe follows drive_en", pin_oe, 1);
            measure(2, g);
            check(g == d + 1, "R5 pin 16x half period", g, d + 1);
            pin_rate_16x = 1'b0;
            measure(2, g);
            check(g == 16 * (d + 1), "R6 pin 1x half period", g, 16 * (d + 1));
        end
        drive_en = 1'b0;
        repeat (3) @(negedge clk);
        check(pin_oe == 1'b0 && pin_out == 1'b0, "R5 pin released", {pin_oe, pin_out}, 0);

        // R3 external source on both sides, pin period 4 clocks
        ext_half = 2;
        tx_src_ext = 1'b1;
        rx_src_ext = 1'b1;
        measure(0, g);
        check(g == 64, "R3 tx external period", g, 64);
        measure(1, g);
        check(g == 64, "R3 rx external period", g, 64);

        // R4 mixed sources
        divisor = 8'd3;
        tx_src_ext = 1'b0;
        measure(0, g);
        check(g == 128, "R4 tx internal while rx external", g, 128);
        measure(1, g);
        check(g == 64, "R4 rx external while tx internal", g, 64);
        tx_src_ext = 1'b1;
        rx_src_ext = 1'b0;
        measure(0, g);
        check(g == 64, "R4 tx external while rx internal", g, 64);
        measure(1, g);
        check(g == 128, "R4 rx internal while tx external", g, 128);
        tx_src_ext = 1'b0;

        // R7 / R8 gated master
        sync_mode = 1'b1;
        master = 1'b1;
        for (int d = 0; d < 7; d += 2) begin
            divisor = 8'(d);
            e = (d < 3) ? 3 : d;
            shift_active = 1'b0;
            repeat (2 * (e + 1) + 4) @(negedge clk);
            count_ticks(40, t);
            check(t == 0 && pin_out == 1'b0, "R8 idle quiet", t, 0);
            check(pin_oe == 1'b1, "R7 master drives pin", pin_oe, 1);
            shift_active = 1'b1;
            lat = 0;
            while (!pin_out && lat < 200) begin
                @(negedge clk);
                lat++;
            end
            check(lat == e + 1, "R8 first rise latency", lat, e + 1);
            check(rx_tick == 1'b1, "R7 rx_tick on rise", rx_tick, 1);
            gap(0, g);
            check(g == e + 1, "R7 tx_tick after rise", g, e + 1);
            check(pin_out == 1'b0, "R7 tx_tick on fall", pin_out, 0);
            measure(2, g);
            check(g == e + 1, "R7 gated half period", g, e + 1);
            measure(1, g);
            check(g == 2 * (e + 1), "R7 rx period", g, 2 * (e + 1));
            shift_active = 1'b0;
            repeat (2 * (e + 1) + 2) @(negedge clk);
            check(pin_out == 1'b0, "R8 settles low after stop", pin_out, 0);
            count_ticks(30, t);
            check(t == 0, "R8 ticks stop", t, 0);
        end

        // R9 gated slave, pin period 6 clocks
        master = 1'b0;
        ext_half = 3;
        shift_active = 1'b1;
        repeat (4) @(negedge clk);
        check(pin_oe == 1'b0, "R9 slave releases pin", pin_oe, 0);
        measure(1, g);
        check(g == 6, "R9 rx per rising edge", g, 6);
        measure(0, g);
        check(g == 6, "R9 tx per falling edge", g, 6);
        shift_active = 1'b0;
        repeat (2) @(negedge clk);
        count_ticks(60, t);
        check(t == 0, "R9 gated off", t, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule